// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a SPI bus master controlled through a small 32-bit register bus. Software selects a word width of 8 or 16 bits, the clock polarity and phase, the bit order for each direction, and the point at which the incoming line is sampled. It then writes a word to the transmit register. The block shifts that word out on MOSI and assembles the word arriving on MISO at the same time. When the word is done, it raises a completion flag, which software clears by writing zero.

One of eight active-low select lines can be driven low. The line is chosen by an index in the control register and is driven low only while the control register's enable bit is set. Select handling is independent of transfers, so several words can be sent under one select. A separate tick generator divides the core clock into SCK half periods. The register bus is a plain single-cycle write strobe with combinational read data.

Top module: `spi_regmst`

## Requirements
- R1: After reset, every register reads zero except the timing register, which reads 0x40 (sample field = 1). All select lines are high and SCK is low.
- R2: Control register (offset 0x00): bit 0 enables selection and bits 4:2 hold an index from 0 to 7. While bit 0 is set, exactly select line `cs_n[index]` is low. While bit 0 is clear, all select lines are high.
- R3: Configuration register (offset 0x04): bit 11 sets the SCK idle level (polarity) and bit 12 sets the phase. With phase 0, MISO is sampled on the first edge of each bit and MOSI changes on the second edge. With phase 1, MOSI changes on the first edge and MISO is sampled on the second. SCK returns to the idle level after each word.
- R4: Configuration bit 5 set selects 16-bit words (32 SCK edges). Bit 5 clear selects 8-bit words (16 SCK edges), which use bits 7:0 of the word.
- R5: Configuration bit 13 set sends the transmit word least significant bit first. Clear sends it most significant bit first.
- R6: Configuration bit 14 set places the first received bit into bit 0 of the received word. Clear places it into the top bit of the word (bit 7 or bit 15).
- R7: A write to the transmit register (offset 0x08) while no word is in progress starts one word, using write-data bits 15:0. A write to that register during a word is ignored: the word in flight, the register's read value and the flag are unaffected, and no further word starts.
- R8: The write that starts a word is taken at clock edge W. The flag (bit 0 of the event register, offset 0x10) reads 0 after edge W+2·N·HALF_DIV and reads 1 after edge W+2·N·HALF_DIV+1, where N is the word width. At that same edge, the received word is loaded into the receive register (offset 0x0C), with bits above N reading zero.
- R9: Writing a value with bit 0 clear to the event register clears the flag. Writing a value with bit 0 set leaves the flag unchanged.
- R10: Timing register (offset 0x18): bits 7:6 select the sample point. Value 2 captures MISO one core clock after the SCK edge on which it is sampled. Any other value captures it at that edge.
- R11: Each SCK half period lasts HALF_DIV core clocks. The first SCK edge of a word comes HALF_DIV clocks after the starting write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low select lines |

## Verification
The assertions assume that HALF_DIV is at least 2. Under that assumption a late capture can never coincide with the next SCK edge, and consecutive ticks never occur back to back. They also assume that each register write lasts exactly one strobe cycle.

The bench meets these assumptions by using a divider of 3 and writing registers only from single-cycle tasks. It changes the configuration and re-arms its serial slave model only while no word is in progress. This keeps any change of SCK idle level from being seen as a bus edge.

// File: rtl/spi_regmst_pkg.sv
package spi_regmst_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_TXD  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_RXD  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_EVT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_TIM  = 8'h18;

  localparam int B_SEL_EN  = 0;
  localparam int B_SEL_IDX = 2;
  localparam int B_WIDE    = 5;
  localparam int B_CPOL    = 11;
  localparam int B_CPHA    = 12;
  localparam int B_TX_LSB  = 13;
  localparam int B_RX_LSB  = 14;
  localparam int B_SAMPLE  = 6;

  localparam logic [1:0] SAMPLE_LATE = 2'd2;
  localparam logic [1:0] SAMPLE_RST  = 2'd1;

  typedef struct packed {
    logic wide;
    logic cpol;
    logic cpha;
    logic tx_lsb;
    logic rx_lsb;
    logic late;
  } xfer_mode_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} eng_state_t;
endpackage

// File: rtl/spi_regmst_tick.sv
module spi_regmst_tick #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = en && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!en || tick)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R11: ticks are spaced by at least two core clocks
  a_r11_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spi_regmst_engine.sv
module spi_regmst_engine
  import spi_regmst_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  xfer_mode_t        mode_in,
  input  logic [WORD_W-1:0] tx_in,
  input  logic              tick,
  input  logic              miso,
  output logic              run,
  output logic              busy,
  output logic              done,
  output logic              sck_q,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_out
);
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int EDGE_W = IDX_W + 1;

  eng_state_t        state;
  xfer_mode_t        mode_q;
  logic [WORD_W-1:0] txw, rxw, rx_next;
  logic [EDGE_W-1:0] edge_cnt, last_edge;
  logic [IDX_W-1:0]  bit_p, rx_k, top_idx, tx_idx, rx_idx;
  logic              sck_r, pend;
  logic              leading, samp_edge, shift_edge, cap_now;

  assign top_idx    = mode_q.wide ? IDX_W'(WORD_W - 1) : IDX_W'(NARROW_W - 1);
  assign last_edge  = {top_idx, 1'b1};
  assign leading    = ~edge_cnt[0];
  assign samp_edge  = tick && (leading ^ mode_q.cpha);
  assign shift_edge = tick && !(leading ^ mode_q.cpha)
                      && !(mode_q.cpha && (edge_cnt == '0));
  assign cap_now    = mode_q.late ? pend : samp_edge;
  assign tx_idx     = mode_q.tx_lsb ? bit_p : (top_idx - bit_p);
  assign rx_idx     = mode_q.rx_lsb ? rx_k  : (top_idx - rx_k);

  always_comb begin
    rx_next = rxw;
    if (cap_now) rx_next[rx_idx] = miso;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mode_q   <= '0;
      txw      <= '0;
      rxw      <= '0;
      edge_cnt <= '0;
      bit_p    <= '0;
      rx_k     <= '0;
      sck_r    <= 1'b0;
      pend     <= 1'b0;
    end else begin
      rxw  <= rx_next;
      pend <= samp_edge && mode_q.late;
      if (cap_now) rx_k <= rx_k + 1'b1;
      unique case (state)
        ST_IDLE: if (start) begin
          mode_q   <= mode_in;
          txw      <= tx_in;
          rxw      <= '0;
          edge_cnt <= '0;
          bit_p    <= '0;
          rx_k     <= '0;
          sck_r    <= mode_in.cpol;
          pend     <= 1'b0;
          state    <= ST_RUN;
        end
        ST_RUN: if (tick) begin
          sck_r    <= ~sck_r;
          edge_cnt <= edge_cnt + 1'b1;
          if (shift_edge && (bit_p != top_idx)) bit_p <= bit_p + 1'b1;
          if (edge_cnt == last_edge) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign run    = (state == ST_RUN);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FIN);
  assign sck_q  = sck_r;
  assign mosi   = busy & txw[tx_idx];
  assign rx_out = rx_next;

  // R3: SCK only moves on a divider tick while a word runs
  a_r3_sck_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(sck_r));
  // R3: an even number of edges brings SCK back to its idle level
  a_r3_end_level: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sck_r == mode_q.cpol));
  // R4: the edge counter never passes the last edge of the word
  a_r4_edge_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (edge_cnt <= last_edge));
  // R7: a start request from idle enters the running state
  a_r7_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> run);
  // R8: completion lasts exactly one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/spi_regmst.sv
module spi_regmst
  import spi_regmst_pkg::*;
#(
  parameter int HALF_DIV = 3,
  parameter int NUM_CS   = 8,
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic              sel_en;
  logic [CS_W-1:0]   sel_idx;
  xfer_mode_t        cfg_q, mode_in;
  logic [1:0]        sample_sel;
  logic [WORD_W-1:0] txd_q, rxd_q, rx_out;
  logic              evt_q;
  logic              busy, run, done, tick, sck_eng, start;
  logic              wdata_unused;

  assign wdata_unused = ^reg_wdata[DATA_W-1:WORD_W];

  logic wr_ctrl, wr_cfg, wr_txd, wr_evt, wr_tim;
  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_cfg  = reg_wr && (reg_addr == OFS_CFG);
  assign wr_txd  = reg_wr && (reg_addr == OFS_TXD);
  assign wr_evt  = reg_wr && (reg_addr == OFS_EVT);
  assign wr_tim  = reg_wr && (reg_addr == OFS_TIM);
  assign start   = wr_txd && !busy;

  always_comb begin
    mode_in      = cfg_q;
    mode_in.late = (sample_sel == SAMPLE_LATE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_en     <= 1'b0;
      sel_idx    <= '0;
      cfg_q      <= '0;
      sample_sel <= SAMPLE_RST;
      txd_q      <= '0;
      rxd_q      <= '0;
      evt_q      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sel_en  <= reg_wdata[B_SEL_EN];
        sel_idx <= reg_wdata[B_SEL_IDX +: CS_W];
      end
      if (wr_cfg) begin
        cfg_q.wide   <= reg_wdata[B_WIDE];
        cfg_q.cpol   <= reg_wdata[B_CPOL];
        cfg_q.cpha   <= reg_wdata[B_CPHA];
        cfg_q.tx_lsb <= reg_wdata[B_TX_LSB];
        cfg_q.rx_lsb <= reg_wdata[B_RX_LSB];
      end
      if (wr_tim) sample_sel <= reg_wdata[B_SAMPLE +: 2];
      if (start)  txd_q <= reg_wdata[WORD_W-1:0];
      if (done)   rxd_q <= rx_out;
      if (done)                          evt_q <= 1'b1;
      else if (wr_evt && !reg_wdata[0])  evt_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[B_SEL_EN]          = sel_en;
        reg_rdata[B_SEL_IDX +: CS_W] = sel_idx;
      end
      OFS_CFG: begin
        reg_rdata[B_WIDE]   = cfg_q.wide;
        reg_rdata[B_CPOL]   = cfg_q.cpol;
        reg_rdata[B_CPHA]   = cfg_q.cpha;
        reg_rdata[B_TX_LSB] = cfg_q.tx_lsb;
        reg_rdata[B_RX_LSB] = cfg_q.rx_lsb;
      end
      OFS_TXD: reg_rdata[WORD_W-1:0] = txd_q;
      OFS_RXD: reg_rdata[WORD_W-1:0] = rxd_q;
      OFS_EVT: reg_rdata[0] = evt_q;
      OFS_TIM: reg_rdata[B_SAMPLE +: 2] = sample_sel;
      default: reg_rdata = '0;
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CS; gi++) begin : g_sel
      assign cs_n[gi] = !(sel_en && (sel_idx == CS_W'(gi)));
    end
  endgenerate

  spi_regmst_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(run), .tick(tick)
  );

  spi_regmst_engine #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_in),
    .tx_in(reg_wdata[WORD_W-1:0]), .tick(tick), .miso(miso),
    .run(run), .busy(busy), .done(done), .sck_q(sck_eng),
    .mosi(mosi), .rx_out(rx_out)
  );

  assign sck = busy ? sck_eng : cfg_q.cpol;

  // R2: never more than one select line low
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R8: completion raises the flag
  a_r8_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> evt_q);
  // R9: a write with bit 0 clear drops the flag
  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !reg_wdata[0] && !done) |=> !evt_q);
  // R7: transmit writes during a word leave the register alone
  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && busy) |=> $stable(txd_q));
endmodule

// File: tb/tb_spi_regmst.sv
`timescale 1ns/1ps
module tb_spi_regmst;
  localparam int HD = 3;
  localparam logic [7:0] A_CTRL = 8'h00, A_CFG = 8'h04, A_TXD = 8'h08,
                         A_RXD = 8'h0C, A_EVT = 8'h10, A_TIM = 8'h18;

  typedef struct packed {
    logic wide; logic cpol; logic cpha; logic txl; logic rxl;
    logic [1:0] dly; logic [15:0] tx; logic [15:0] sw;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,16'h00A5,16'h003C},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,2'd1,16'h001E,16'h006B},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,2'd2,16'h005A,16'h000F},
    '{1'b0,1'b1,1'b1,1'b1,1'b1,2'd2,16'h00C4,16'h0091},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,16'hBEEF,16'h1234},
    '{1'b1,1'b1,1'b1,1'b1,1'b0,2'd2,16'h8001,16'hFEDC},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,2'd0,16'h0077,16'h00E1},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,2'd3,16'h0F0F,16'hA5C3}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata, rd;
  logic        sck, mosi, miso_b = 1'b0;
  logic [7:0]  cs_n;
  int          n_chk = 0, n_bad = 0;

  logic        s_arm = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0, s_jit = 1'b0, s_first = 1'b0;
  int          s_n = 8, s_ptr = 0;
  logic [15:0] s_word = '0, mrec = '0;

  always #2.5 clk = ~clk;

  spi_regmst #(.HALF_DIV(HD)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
    .miso(miso_b), .cs_n(cs_n)
  );

  // serial slave model: sends s_word first bit = top bit, records mosi
  always @(sck) begin
    if (s_arm) begin
      if ((sck != s_cpol) ^ s_cpha) begin
        if (s_jit) miso_b = 1'b1;
        else mrec = {mrec[14:0], mosi};
      end else begin
        if (s_jit) miso_b = 1'b0;
        else if (s_cpha && (sck != s_cpol) && s_first) s_first = 1'b0;
        else begin
          s_ptr++;
          if (s_ptr < s_n) miso_b = s_word[s_n-1-s_ptr];
        end
      end
    end
  end

  function automatic logic [15:0] flip(input logic [15:0] v, input int n);
    logic [15:0] o = '0;
    for (int k = 0; k < n; k++) o[k] = v[n-1-k];
    return o;
  endfunction

  function automatic logic [15:0] wmask(input int n);
    return (n == 16) ? 16'hFFFF : 16'h00FF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a);
    reg_addr = a;
    #1 rd = reg_rdata;
  endtask

  task automatic arm(input logic cp, input logic ph, input logic jit,
                     input int n, input logic [15:0] w);
    s_cpol = cp; s_cpha = ph; s_jit = jit; s_n = n; s_word = w;
    s_ptr = 0; s_first = 1'b1; mrec = '0;
    miso_b = jit ? 1'b0 : w[n-1];
    s_arm = 1'b1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    vec_t v;
    int n, idx;
    logic [7:0] e_cs;
    logic [15:0] e_tx, e_rx;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(A_CTRL); chk("R1 control reset", rd, 32'h0);
    peek(A_CFG);  chk("R1 config reset", rd, 32'h0);
    peek(A_TXD);  chk("R1 transmit reset", rd, 32'h0);
    peek(A_RXD);  chk("R1 receive reset", rd, 32'h0);
    peek(A_EVT);  chk("R1 flag reset", rd, 32'h0);
    peek(A_TIM);  chk("R1 timing reset", rd, 32'h40);
    chk("R1 selects high", {24'h0, cs_n}, 32'hFF);
    chk("R1 sck low", {31'h0, sck}, 32'h0);

    // R2 select decode
    for (int i = 0; i < 8; i++) begin
      wr(A_CTRL, (i << 2) | 1);
      e_cs = ~(8'd1 << i);
      chk("R2 indexed select low", {24'h0, cs_n}, {24'h0, e_cs});
    end
    wr(A_CTRL, 5 << 2);
    chk("R2 disabled selects high", {24'h0, cs_n}, 32'hFF);

    // vector table walk
    for (int i = 0; i < 8; i++) begin
      v = VECS[i];
      n = v.wide ? 16 : 8;
      idx = (i * 3) % 8;
      wr(A_CFG, (32'(v.wide) << 5) | (32'(v.cpol) << 11) | (32'(v.cpha) << 12)
              | (32'(v.txl) << 13) | (32'(v.rxl) << 14));
      wr(A_TIM, 32'(v.dly) << 6);
      wr(A_CTRL, (idx << 2) | 1);
      wr(A_EVT, 32'h0);
      arm(v.cpol, v.cpha, 1'b0, n, v.sw);
      wr(A_TXD, {16'h0, v.tx});
      repeat (HD - 1) @(negedge clk);
      chk("R11 sck idle before first edge", {31'h0, sck}, {31'h0, v.cpol});
      @(negedge clk);
      chk("R11 first sck edge", {31'h0, sck}, {31'h0, ~v.cpol});
      repeat (2 * n * HD - HD) @(negedge clk);
      peek(A_EVT); chk("R4 R8 flag still clear", rd, 32'h0);
      @(negedge clk);
      peek(A_EVT); chk("R4 R8 flag raised", rd, 32'h1);
      e_rx = v.rxl ? flip(v.sw, n) : (v.sw & wmask(n));
      e_tx = v.txl ? flip(v.tx, n) : (v.tx & wmask(n));
      peek(A_RXD); chk("R6 R8 received word", rd, {16'h0, e_rx});
      chk("R5 transmitted bits", {16'h0, mrec & wmask(n)}, {16'h0, e_tx});
      e_cs = ~(8'd1 << idx);
      chk("R2 select during word", {24'h0, cs_n}, {24'h0, e_cs});
      chk("R3 sck back at idle", {31'h0, sck}, {31'h0, v.cpol});
      s_arm = 1'b0;
    end

    // R7 write during a word is ignored
    wr(A_CFG, 32'h0); wr(A_TIM, 32'h40); wr(A_CTRL, 32'h1); wr(A_EVT, 32'h0);
    arm(1'b0, 1'b0, 1'b0, 8, 16'h0055);
    wr(A_TXD, 32'hA5);
    repeat (4) @(negedge clk);
    wr(A_TXD, 32'h3C);
    repeat (2 * 8 * HD) @(negedge clk);
    peek(A_EVT); chk("R7 first word completed", rd, 32'h1);
    chk("R7 in-flight word kept", {16'h0, mrec & 16'h00FF}, 32'hA5);
    peek(A_TXD); chk("R7 transmit register kept", rd, 32'hA5);
    s_arm = 1'b0;

    // R9 flag clearing
    wr(A_EVT, 32'h1);
    peek(A_EVT); chk("R9 nonzero write keeps flag", rd, 32'h1);
    wr(A_EVT, 32'h0);
    peek(A_EVT); chk("R9 zero write clears flag", rd, 32'h0);
    repeat (2 * 8 * HD + 4) @(negedge clk);
    peek(A_EVT); chk("R7 ignored write started nothing", rd, 32'h0);

    // R10 sample point, slave flips miso right after each sampling edge
    for (int ph = 0; ph < 2; ph++) begin
      wr(A_CFG, 32'(ph) << 12);
      wr(A_TIM, 32'h40);
      arm(1'b0, ph[0], 1'b1, 8, 16'h0);
      wr(A_TXD, 32'h0);
      repeat (2 * 8 * HD + 2) @(negedge clk);
      peek(A_RXD); chk("R10 nominal capture", rd, 32'h00);
      wr(A_TIM, 32'h80);
      arm(1'b0, ph[0], 1'b1, 8, 16'h0);
      wr(A_TXD, 32'h0);
      repeat (2 * 8 * HD + 2) @(negedge clk);
      peek(A_RXD); chk("R10 late capture", rd, 32'hFF);
      s_arm = 1'b0;
    end
    peek(A_TIM); chk("R10 timing field readback", rd, 32'h80);

    finish_run();
  end
endmodule